// File: doc/BRIEF.md
# Feedback and Post-Scaler Clock Divider Pair

This block holds the two counters of a frequency synthesizer. Both run on the fast oscillator clock. The first counter is the loop divider. It counts a 9-bit ratio M and emits a single-cycle comparison pulse, which a phase comparator outside this block lines up with the reference. When the loop is locked, the oscillator therefore runs at M times the reference. The second counter is a post-scaler. A 2-bit code selects a division of 1, 2, 4 or 8, and the result drives a set of complementary clock output pairs.

A synchronous master reset holds both counters at their start point. While it is held, every true output is low and every inverted output is high. Reset does not clear the ratio selections: the active copies of M and the output code keep following the inputs, so the divider resumes with the present values as soon as reset is released.

A new M or output code never cuts a period short. The post-scaler adopts a new code when its true output falls. The loop divider adopts a new M on the edge that produces its pulse. In divide-by-1 the output is the oscillator clock itself, passed through a mux rather than a counter.

Top module: `synth_div_core`

## Requirements
- R1: The output code selects the division ratio as 2 to the power of the code value: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8.
- R2: For a ratio D above 1, the true output is registered on rising clock edges. It stays high for D/2 edges and low for D/2 edges. After reset it starts low and rises on the D/2-th edge of each period.
- R3: While `mreset` is high, every `out_t` bit is 0, every `out_c` bit is 1 and `fb_pulse` is 0.
- R4: Releasing `mreset` needs no reload. The first period after release uses the M and output code present on the last reset edge.
- R5: `fb_pulse` is high for exactly one cycle out of every M rising edges, with M read as an unsigned binary value (bit 8 weighs 256, bit 0 weighs 1). After release, the first pulse follows the M-th edge.
- R6: An M of 0 or 1 divides by one, so `fb_pulse` is high on every cycle while running.
- R7: All output pairs carry identical levels at all times, and each `out_c` bit is the complement of its `out_t` bit.
- R8: With ratio 1 selected and reset low, `out_t` follows the oscillator clock (high in its high phase, low in its low phase).
- R9: A change of the output code takes effect only on the edge where the true output falls, closing a full period. When the active ratio is 1, the change is taken on the next rising edge.
- R10: A change of M takes effect only on the edge that produces a feedback pulse. The count in progress completes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-rate clock driving both dividers |
| mreset | input | 1 | Master reset, active high, sampled on rising edges; also forces output levels at once |
| m_val | input | 9 | Loop division ratio M |
| n_code | input | 2 | Output ratio code (0:/1, 1:/2, 2:/4, 3:/8) |
| fb_pulse | output | 1 | One-cycle pulse at the loop divider's terminal count |
| out_t | output | 2 | True clock outputs, one bit per pair |
| out_c | output | 2 | Inverted clock outputs, one bit per pair |

## Verification
Two events can fall on the same edge: a change of a ratio input and the terminal count that is allowed to adopt it. For each divider, the bench watches its own reference model and moves `n_code` or `m_val` in the half cycle just before the falling output edge or the pulse edge. The model then decides whether the old or the new ratio governs the next period, and every output is compared on both clock phases. Reset is also asserted and released in the middle of a period while the ratio inputs move underneath it, which shows that release picks up the values present on the last reset edge.

// File: rtl/synth_div_pkg.sv
`timescale 1ns/1ps
package synth_div_pkg;

   // one complementary output pair
   typedef struct packed {
      logic t;
      logic c;
   } diff_pair_t;

   // largest output ratio exponent a code of the given width can select
   function automatic int unsigned max_exp(input int unsigned code_w);
      return (1 << code_w) - 1;
   endfunction

   // bits needed for a half-period counter at the largest ratio
   function automatic int unsigned half_cnt_w(input int unsigned code_w);
      return (max_exp(code_w) > 1) ? max_exp(code_w) - 1 : 1;
   endfunction

endpackage

// File: rtl/fb_divider.sv
`timescale 1ns/1ps
module fb_divider #(
   parameter int unsigned MW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [MW-1:0] m_in,
   output logic          pulse,
   output logic [MW-1:0] m_act
);

   logic [MW-1:0] cnt;
   logic [MW-1:0] last;

   // ratios 0 and 1 both end the count on every edge
   always_comb begin
      if (m_act < MW'(2)) last = '0;
      else                last = m_act - MW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         pulse <= 1'b0;
         m_act <= m_in;
      end else if (cnt == last) begin
         cnt   <= '0;
         pulse <= 1'b1;
         m_act <= m_in;
      end else begin
         cnt   <= cnt + MW'(1);
         pulse <= 1'b0;
      end
   end

endmodule

// File: rtl/post_divider.sv
`timescale 1ns/1ps
module post_divider
   import synth_div_pkg::*;
#(
   parameter int unsigned NW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NW-1:0] n_in,
   output logic          q,
   output logic          bypass,
   output logic [NW-1:0] n_act
);

   localparam int unsigned CW = half_cnt_w(NW);
   localparam int unsigned SW = max_exp(NW) + 1;

   logic [CW-1:0] cnt;
   logic [SW-1:0] span;
   logic [CW-1:0] half_m1;

   always_comb begin
      span    = SW'(1) << n_act;
      half_m1 = CW'((span >> 1) - SW'(1));
   end

   assign bypass = (n_act == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         q     <= 1'b0;
         n_act <= n_in;
      end else if (bypass) begin
         // no counter in divide-by-one; every edge closes a period
         cnt   <= '0;
         q     <= 1'b0;
         n_act <= n_in;
      end else if (cnt == half_m1) begin
         cnt <= '0;
         q   <= ~q;
         if (q) n_act <= n_in;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/out_stage.sv
`timescale 1ns/1ps
module out_stage
   import synth_div_pkg::*;
#(
   parameter int unsigned PAIRS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bypass,
   input  logic             q,
   output logic [PAIRS-1:0] pt,
   output logic [PAIRS-1:0] pc
);

   diff_pair_t sel;

   always_comb begin
      if (rst)         sel.t = 1'b0;
      else if (bypass) sel.t = clk;
      else             sel.t = q;
      sel.c = ~sel.t;
   end

   for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      assign pt[i] = sel.t;
      assign pc[i] = sel.c;
   end

endmodule

// File: rtl/synth_div_core.sv
`timescale 1ns/1ps
module synth_div_core #(
   parameter int unsigned MW    = 9,
   parameter int unsigned NW    = 2,
   parameter int unsigned PAIRS = 2
) (
   input  logic             clk_vco,
   input  logic             mreset,
   input  logic [MW-1:0]    m_val,
   input  logic [NW-1:0]    n_code,
   output logic             fb_pulse,
   output logic [PAIRS-1:0] out_t,
   output logic [PAIRS-1:0] out_c
);

   if (MW < 2) begin : g_mw_bad
      $error("synth_div_core: MW must be at least 2");
   end
   if (NW < 1 || NW > 3) begin : g_nw_bad
      $error("synth_div_core: NW must lie in 1..3");
   end
   if (PAIRS < 1) begin : g_pairs_bad
      $error("synth_div_core: PAIRS must be at least 1");
   end

   logic [MW-1:0] m_act_w;
   logic [NW-1:0] n_act_w;
   logic          div_q_w;
   logic          bypass_w;

   fb_divider #(.MW(MW)) u_fb (
      .clk   (clk_vco),
      .rst   (mreset),
      .m_in  (m_val),
      .pulse (fb_pulse),
      .m_act (m_act_w)
   );

   post_divider #(.NW(NW)) u_post (
      .clk    (clk_vco),
      .rst    (mreset),
      .n_in   (n_code),
      .q      (div_q_w),
      .bypass (bypass_w),
      .n_act  (n_act_w)
   );

   out_stage #(.PAIRS(PAIRS)) u_out (
      .clk    (clk_vco),
      .rst    (mreset),
      .bypass (bypass_w),
      .q      (div_q_w),
      .pt     (out_t),
      .pc     (out_c)
   );

endmodule

// File: rtl/synth_div_core_chk.sv
`timescale 1ns/1ps
module synth_div_core_chk #(
   parameter int unsigned MW    = 9,
   parameter int unsigned NW    = 2,
   parameter int unsigned PAIRS = 2
) (
   input logic             clk,
   input logic             rst,
   input logic [MW-1:0]    m_val,
   input logic [NW-1:0]    n_code,
   input logic             fb_pulse,
   input logic [PAIRS-1:0] out_t,
   input logic [PAIRS-1:0] out_c,
   input logic [MW-1:0]    m_act,
   input logic [NW-1:0]    n_act,
   input logic             div_q
);

   // R3
   always @(negedge clk) begin
      if (rst) begin
         reset_levels_chk: assert (out_t == '0 && out_c == '1 && !fb_pulse);
      end
   end

   // R5
   fb_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      (fb_pulse && ($past(m_val) > MW'(1))) |=> !fb_pulse);

   // R4
   keep_config_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> ((m_act == $past(m_val)) && (n_act == $past(n_code))));

   // R9
   code_swap_chk: assert property (@(posedge clk) disable iff (rst)
      ($changed(n_act) && !$past(rst)) |-> ($fell(div_q) || ($past(n_act) == '0)));

   // R2
   div8_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((n_act == NW'(3)) && $rose(div_q)) |=> $stable(div_q));

endmodule

bind synth_div_core synth_div_core_chk #(.MW(MW), .NW(NW), .PAIRS(PAIRS)) u_chk (
   .clk      (clk_vco),
   .rst      (mreset),
   .m_val    (m_val),
   .n_code   (n_code),
   .fb_pulse (fb_pulse),
   .out_t    (out_t),
   .out_c    (out_c),
   .m_act    (m_act_w),
   .n_act    (n_act_w),
   .div_q    (div_q_w)
);

// File: tb/synth_div_core_bench.sv
`timescale 1ns/1ps
module synth_div_core_bench;

   logic       clk_vco = 1'b0;
   logic       mreset;
   logic [8:0] m_val;
   logic [1:0] n_code;
   logic       fb_pulse;
   logic [1:0] out_t;
   logic [1:0] out_c;

   int checks = 0;
   int errors = 0;
   string cur_req = "R3";

   // reference model state
   int ncur, op, mcur, mp;
   bit eq, ep, started = 0;

   synth_div_core u_synth_div_core (
      .clk_vco  (clk_vco),
      .mreset   (mreset),
      .m_val    (m_val),
      .n_code   (n_code),
      .fb_pulse (fb_pulse),
      .out_t    (out_t),
      .out_c    (out_c)
   );

   always #2 clk_vco = ~clk_vco;

   // model advances on every rising edge from the requirements
   always @(posedge clk_vco) begin
      int meff, d;
      started = 1;
      if (mreset) begin
         ncur = int'(n_code); op = 0; eq = 0;
         mcur = int'(m_val);  mp = 0; ep = 0;
      end else begin
         meff = (mcur < 2) ? 1 : mcur;
         mp++;
         if (mp == meff) begin ep = 1; mp = 0; mcur = int'(m_val); end
         else ep = 0;
         d = 1 << ncur;
         if (d == 1) begin
            eq = 0; op = 0; ncur = int'(n_code);
         end else begin
            op++;
            eq = (op >= d / 2) && (op < d);
            if (op == d) begin eq = 0; op = 0; ncur = int'(n_code); end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit et;
      et = mreset ? 1'b0 : ((ncur == 0) ? clk_vco : eq);
      check(fb_pulse == ep, cur_req, "fb_pulse", int'(fb_pulse), int'(ep));
      check(out_t == {2{et}}, {cur_req, " R7"}, "out_t", int'(out_t), int'({2{et}}));
      check(out_c == {2{~et}}, {cur_req, " R7"}, "out_c", int'(out_c), int'({2{~et}}));
   endtask

   always @(posedge clk_vco) begin #0.5; if (started) compare(); end
   always @(negedge clk_vco) begin #0.5; if (started) compare(); end

   task automatic step(input int n);
      repeat (n) @(negedge clk_vco);
      #1;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      mreset = 1'b1; m_val = 9'd5; n_code = 2'd2;
      cur_req = "R3";
      step(5);
      // R4 R5 R1 R2: release with the values held through reset
      cur_req = "R4 R5 R1 R2";
      mreset = 1'b0;
      step(40);
      // R1 R2 R9: divide by 8, code change mid-period
      cur_req = "R1 R2 R9";
      n_code = 2'd3;
      step(10);
      n_code = 2'd1;
      step(30);
      // R8: divide by one follows the clock
      cur_req = "R8 R9";
      n_code = 2'd0;
      step(20);
      n_code = 2'd2;
      step(20);
      // R6: ratios 0 and 1
      cur_req = "R6";
      m_val = 9'd0;
      step(20);
      m_val = 9'd1;
      step(20);
      // R5: large ratio with the high weight bit
      cur_req = "R5";
      m_val = 9'd300;
      step(700);
      // R10: change M while a count runs
      cur_req = "R10";
      m_val = 9'd7;
      step(3);
      m_val = 9'd4;
      step(40);
      // coincidence: code change on the cycle before the falling edge
      cur_req = "R9";
      n_code = 2'd3;
      step(20);
      while (!(ncur == 3 && op == 7)) step(1);
      n_code = 2'd1;
      step(20);
      // coincidence: M change on the cycle before the pulse edge
      cur_req = "R10";
      while (mp != ((mcur < 2 ? 1 : mcur) - 1)) step(1);
      m_val = 9'd6;
      step(30);
      // R3 R4: reset mid-period with inputs moving underneath
      cur_req = "R3";
      n_code = 2'd3;
      step(13);
      mreset = 1'b1;
      step(2);
      m_val = 9'd3; n_code = 2'd2;
      step(3);
      cur_req = "R4";
      mreset = 1'b0;
      step(30);
      // mixed traffic
      cur_req = "R1 R5 R9 R10";
      for (int i = 0; i < 400; i++) begin
         m_val  = 9'($urandom_range(0, 12));
         n_code = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 15) == 0) begin
            mreset = 1'b1;
            step(2);
            mreset = 1'b0;
         end
         step($urandom_range(1, 20));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule